// File: doc/BRIEF.md
# CSR Read-and-Clear-Immediate Unit

This unit carries out the read-and-clear-with-immediate form of control/status register access for a processor core. The core presents a 12-bit register address, a 5-bit unsigned immediate, the destination register number and a valid strobe. On the next cycle the unit returns the register's value as it stood before the access. In the same clock edge it clears, in that register, every bit that is set in the zero-extended immediate. When the immediate is zero the register is not written at all, so the access is a pure read.

A small bank of plain 32-bit registers sits at consecutive addresses starting at a base address. An access to any other address returns zero, raises an error flag and writes nothing. The response also carries a write-back enable, so the core can skip the register-file write when the destination is register 0. The reset contents of each register are a parameter; the default is all zeros.

Top module: `csr_clrimm_unit`

## Requirements
- R1: Each cycle with `req_valid_i` high produces `rsp_done_o` high for exactly the following cycle. `rsp_done_o` is never high in a cycle that does not follow a request.
- R2: `rsp_rdata_o` in the response cycle holds the addressed register's value from before the access, whatever the immediate.
- R3: For a nonzero immediate, the addressed register afterwards equals its old value ANDed with the bitwise inverse of the immediate zero-extended to 32 bits. Bit k of the immediate clears bit k of the register, for k in 0..4. Bits 5..31 are never changed.
- R4: For a zero immediate, the addressed register is not modified.
- R5: `NUM_CSR` registers (default 8) exist at addresses `BASE_ADDR` through `BASE_ADDR+NUM_CSR-1` (default 0x300 to 0x307). Each register holds its own 32-bit value and is independent of the others.
- R6: A request to an address outside that window returns `rsp_rdata_o` = 0 and `rsp_err_o` = 1, and modifies no register, even with a nonzero immediate.
- R7: In a response, `rsp_rd_o` echoes the request's destination number. `rsp_wen_o` is 1 exactly when the address was mapped and that number is not 0.
- R8: A synchronous active-high `rst` loads every register with its reset value (parameter `RST_VALS`, register i in bits 32*i+31 to 32*i) and drives `rsp_done_o` and `rsp_err_o` low. A request presented while `rst` is high is discarded.
- R9: Requests may arrive on consecutive cycles. A request reads the value left by the previous request to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, one request per high cycle |
| csr_addr_i | input | 12 | Register address |
| zimm_i | input | 5 | Unsigned clear mask immediate |
| rd_i | input | 5 | Destination register number of the core |
| rsp_done_o | output | 1 | Response valid, one cycle per request |
| rsp_err_o | output | 1 | Address was not mapped |
| rsp_wen_o | output | 1 | Core should write `rsp_rdata_o` to `rsp_rd_o` |
| rsp_rd_o | output | 5 | Echoed destination number |
| rsp_rdata_o | output | 32 | Register value before the access |

## Verification
The bench aims at the window edges: 0x2FF, 0x300, 0x307 and 0x308, plus distant addresses. An off-by-one decode there would either clear a neighbouring register or report a valid register as unmapped. It chains requests back to back on the same register with zero and nonzero masks. A design that returned the updated value instead of the old one, or that wrote on a zero immediate, would show the wrong value on the following read. It also sends nonzero immediates to unmapped addresses and then reads the whole bank, which exposes any stray write. Destination 0 and a mid-run reset are covered too, the reset restoring distinct per-register values.

// File: rtl/csr_clr_pkg.sv
package csr_clr_pkg;
    localparam int unsigned XW = 32;
    localparam int unsigned RW = 5;

    typedef struct packed {
        logic          done;
        logic          err;
        logic          wen;
        logic [RW-1:0] rd;
        logic [XW-1:0] rdata;
    } csr_rsp_t;
endpackage

// File: rtl/csr_clr_decode.sv
module csr_clr_decode #(
    parameter int unsigned        ADDR_W    = 12,
    parameter int unsigned        NUM_CSR   = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 12'h300,
    parameter int unsigned        IDX_W     = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_CSR-1:0] sel
);
    // One comparator per implemented register.
    for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
        assign sel[g] = (addr == ADDR_W'(int'(BASE_ADDR) + g));
    end

    assign hit = |sel;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (sel[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/csr_clr_mask.sv
module csr_clr_mask #(
    parameter int unsigned IMM_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [IMM_W-1:0]  zimm,
    output logic [DATA_W-1:0] keep,
    output logic              nz
);
    // Bits to keep: inverse of the zero-extended immediate.
    assign keep = ~{{(DATA_W-IMM_W){1'b0}}, zimm};
    assign nz   = |zimm;
endmodule

// File: rtl/csr_clrimm_unit.sv
module csr_clrimm_unit #(
    parameter int unsigned                     ADDR_W    = 12,
    parameter int unsigned                     IMM_W     = 5,
    parameter int unsigned                     NUM_CSR   = 8,
    parameter logic [ADDR_W-1:0]               BASE_ADDR = 12'h300,
    parameter logic [NUM_CSR*csr_clr_pkg::XW-1:0] RST_VALS = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid_i,
    input  logic [ADDR_W-1:0]          csr_addr_i,
    input  logic [IMM_W-1:0]           zimm_i,
    input  logic [csr_clr_pkg::RW-1:0] rd_i,
    output logic                       rsp_done_o,
    output logic                       rsp_err_o,
    output logic                       rsp_wen_o,
    output logic [csr_clr_pkg::RW-1:0] rsp_rd_o,
    output logic [csr_clr_pkg::XW-1:0] rsp_rdata_o
);
    import csr_clr_pkg::*;

    localparam int unsigned DATA_W = XW;
    localparam int unsigned IDX_W  = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1;

    typedef struct packed {
        logic [NUM_CSR-1:0][DATA_W-1:0] regs;
        csr_rsp_t                       rsp;
    } state_t;

    state_t st_d, st_q;

    logic               hit;
    logic [IDX_W-1:0]   idx;
    logic [NUM_CSR-1:0] sel;
    logic [DATA_W-1:0]  keep;
    logic               nz;

    csr_clr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CSR  (NUM_CSR),
        .BASE_ADDR(BASE_ADDR),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr(csr_addr_i),
        .hit (hit),
        .idx (idx),
        .sel (sel)
    );

    csr_clr_mask #(
        .IMM_W (IMM_W),
        .DATA_W(DATA_W)
    ) u_mask (
        .zimm(zimm_i),
        .keep(keep),
        .nz  (nz)
    );

    always_comb begin
        st_d = st_q;
        st_d.rsp.done  = req_valid_i;
        st_d.rsp.err   = req_valid_i && !hit;
        st_d.rsp.wen   = req_valid_i && hit && (rd_i != '0);
        st_d.rsp.rd    = req_valid_i ? rd_i : '0;
        // Old value is taken from the registered bank, before any update.
        st_d.rsp.rdata = (req_valid_i && hit) ? st_q.regs[idx] : '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (req_valid_i && sel[i] && nz) begin
                st_d.regs[i] = st_q.regs[i] & keep;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.regs <= RST_VALS;
            st_q.rsp  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_done_o  = st_q.rsp.done;
    assign rsp_err_o   = st_q.rsp.err;
    assign rsp_wen_o   = st_q.rsp.wen;
    assign rsp_rd_o    = st_q.rsp.rd;
    assign rsp_rdata_o = st_q.rsp.rdata;
endmodule

// File: rtl/csr_clrimm_chk.sv
module csr_clrimm_chk #(
    parameter int unsigned       ADDR_W    = 12,
    parameter int unsigned       IMM_W     = 5,
    parameter int unsigned       NUM_CSR   = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h300
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [IMM_W-1:0]  zimm_i,
    input logic [4:0]        rd_i,
    input logic              rsp_done_o,
    input logic              rsp_err_o,
    input logic              rsp_wen_o,
    input logic [4:0]        rsp_rd_o,
    input logic [31:0]       rsp_rdata_o
);
    logic              in_rng;
    logic              prev_valid_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic [IMM_W-1:0]  prev_zimm_q;
    logic [31:0]       keep_prev;

    assign in_rng = (int'(csr_addr_i) >= int'(BASE_ADDR)) &&
                    (int'(csr_addr_i) <  int'(BASE_ADDR) + NUM_CSR);
    assign keep_prev = ~{{(32-IMM_W){1'b0}}, prev_zimm_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid_q <= 1'b0;
            prev_addr_q  <= '0;
            prev_zimm_q  <= '0;
        end else begin
            prev_valid_q <= req_valid_i && in_rng;
            prev_addr_q  <= csr_addr_i;
            prev_zimm_q  <= zimm_i;
        end
    end

    a_r1_done_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_done_o);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !rsp_done_o);

    a_r6_unmapped_zero_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !in_rng) |=> (rsp_err_o && rsp_rdata_o == '0 && !rsp_wen_o));

    a_r5_mapped_no_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && in_rng) |=> !rsp_err_o);

    a_r7_wb_enable: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && in_rng) |=>
            (rsp_wen_o == ($past(rd_i) != '0)) && (rsp_rd_o == $past(rd_i)));

    // R3 and R4 (R9): a back-to-back access to the same register sees the
    // previous old value with the previous immediate's bits cleared.
    a_r3_clear_chain: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && in_rng && prev_valid_q && csr_addr_i == prev_addr_q) |=>
            (rsp_rdata_o == ($past(rsp_rdata_o) & $past(keep_prev))));

    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rsp_done_o && !rsp_err_o));
endmodule

bind csr_clrimm_unit csr_clrimm_chk #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .NUM_CSR  (NUM_CSR),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid_i),
    .csr_addr_i (csr_addr_i),
    .zimm_i     (zimm_i),
    .rd_i       (rd_i),
    .rsp_done_o (rsp_done_o),
    .rsp_err_o  (rsp_err_o),
    .rsp_wen_o  (rsp_wen_o),
    .rsp_rd_o   (rsp_rd_o),
    .rsp_rdata_o(rsp_rdata_o)
);

// File: tb/tb_csr_clrimm_unit.sv
module tb_csr_clrimm_unit;
    localparam int          N    = 8;
    localparam logic [11:0] BASE = 12'h300;

    function automatic logic [N*32-1:0] mk_inits();
        logic [N*32-1:0] v;
        for (int i = 0; i < N; i++)
            v[i*32 +: 32] = 32'hFFFF_FFFF ^ (32'(i) << 12) ^ (32'(i + 1) << 24);
        return v;
    endfunction

    localparam logic [N*32-1:0] INITS = mk_inits();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [4:0]  zimm_i = '0;
    logic [4:0]  rd_i = '0;
    logic        rsp_done_o, rsp_err_o, rsp_wen_o;
    logic [4:0]  rsp_rd_o;
    logic [31:0] rsp_rdata_o;

    always #5 clk = ~clk;

    csr_clrimm_unit #(.NUM_CSR(N), .BASE_ADDR(BASE), .RST_VALS(INITS)) dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .csr_addr_i(csr_addr_i),
        .zimm_i(zimm_i), .rd_i(rd_i), .rsp_done_o(rsp_done_o), .rsp_err_o(rsp_err_o),
        .rsp_wen_o(rsp_wen_o), .rsp_rd_o(rsp_rd_o), .rsp_rdata_o(rsp_rdata_o)
    );

    logic [31:0] model [N];
    int          vectors = 0;
    int          miscmp  = 0;
    logic        exp_done = 1'b0, exp_err = 1'b0, exp_wen = 1'b0;
    logic [4:0]  exp_rd = '0;
    logic [31:0] exp_rdata = '0;
    string       exp_tag = "R8";

    task automatic report(input string what, input logic [31:0] act, input logic [31:0] exp);
        miscmp++;
        $display("FAIL %s %s: actual %h expected %h", exp_tag, what, act, exp);
    endtask

    task automatic check_prev();
        vectors++;
        if (rsp_done_o !== exp_done) report("done", 32'(rsp_done_o), 32'(exp_done));
        else if (exp_done) begin
            if (rsp_err_o !== exp_err)     report("err", 32'(rsp_err_o), 32'(exp_err));
            if (rsp_rdata_o !== exp_rdata) report("rdata", rsp_rdata_o, exp_rdata);
            if (rsp_wen_o !== exp_wen)     report("wen", 32'(rsp_wen_o), 32'(exp_wen));
            if (rsp_rd_o !== exp_rd)       report("rd", 32'(rsp_rd_o), 32'(exp_rd));
        end else if (rsp_err_o !== 1'b0) report("err idle", 32'(rsp_err_o), 32'd0);
    endtask

    task automatic step(input bit v, input logic [11:0] a, input logic [4:0] z,
                        input logic [4:0] r, input string tag);
        @(negedge clk);
        check_prev();
        exp_done = v;
        exp_tag  = tag;
        exp_rd   = v ? r : 5'd0;
        exp_err = 1'b0; exp_wen = 1'b0; exp_rdata = '0;
        if (v) begin
            if (int'(a) >= int'(BASE) && int'(a) < int'(BASE) + N) begin
                int k = int'(a) - int'(BASE);
                exp_rdata = model[k];
                exp_wen   = (r != 0);
                if (z != 0) model[k] = model[k] & ~{27'd0, z};
            end else begin
                exp_err = 1'b1;
            end
        end
        req_valid_i = v; csr_addr_i = a; zimm_i = z; rd_i = r;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        check_prev();
        rst = 1'b1; req_valid_i = 1'b1; csr_addr_i = BASE; zimm_i = 5'h1F;
        repeat (cycles) @(negedge clk);
        rst = 1'b0; req_valid_i = 1'b0;
        for (int i = 0; i < N; i++) model[i] = INITS[i*32 +: 32];
        exp_done = 1'b0; exp_tag = "R8";
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < N; i++) step(1, BASE + 12'(i), 5'd0, 5'd3, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscmp++;
        $display("FAIL R1 watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = INITS[i*32 +: 32];
        do_reset(3);                        // R8: request held during reset is discarded
        step(0, '0, '0, '0, "R8");          // R8: quiet after reset
        read_all("R8");                     // R8/R5: distinct reset values per register
        // R2/R3: clear returns old value, next read shows cleared bits
        step(1, 12'h300, 5'b10101, 5'd1, "R2");
        step(1, 12'h300, 5'd0, 5'd1, "R3");
        // R4: zero immediate leaves value alone, repeated reads agree
        step(1, 12'h301, 5'd0, 5'd2, "R4");
        step(1, 12'h301, 5'd0, 5'd2, "R4");
        // R9: back-to-back nonzero clears on the same register
        step(1, 12'h302, 5'b00011, 5'd4, "R9");
        step(1, 12'h302, 5'b11000, 5'd4, "R9");
        step(1, 12'h302, 5'd0, 5'd4, "R9");
        // R5: window edges
        step(1, 12'h307, 5'h1F, 5'd5, "R5");
        step(1, 12'h307, 5'd0, 5'd5, "R5");
        // R6: unmapped addresses with nonzero immediates, then verify no write
        step(1, 12'h2FF, 5'h1F, 5'd6, "R6");
        step(1, 12'h308, 5'h1F, 5'd6, "R6");
        step(1, 12'h000, 5'h1F, 5'd6, "R6");
        step(1, 12'hFFF, 5'h1F, 5'd6, "R6");
        step(1, 12'h700, 5'h1F, 5'd0, "R6");
        read_all("R6");
        // R7: destination 0 suppresses write-back, others echoed
        step(1, 12'h304, 5'd0, 5'd0, "R7");
        step(1, 12'h304, 5'd0, 5'd31, "R7");
        // R1: idle gaps produce no response
        step(0, 12'h303, 5'h1F, 5'd7, "R1");
        step(0, 12'h303, 5'h1F, 5'd7, "R1");
        step(1, 12'h303, 5'd0, 5'd7, "R1");
        step(0, '0, '0, '0, "R1");
        // Mixed traffic around the window
        for (int n = 0; n < 400; n++) begin
            logic [4:0] z;
            z = ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
            step($urandom_range(0, 4) != 0, 12'h2FC + 12'($urandom_range(0, 15)), z,
                 5'($urandom_range(0, 31)), "R9");
        end
        read_all("R3");
        // R8: reset mid-run restores reset values
        do_reset(2);
        read_all("R8");
        step(0, '0, '0, '0, "R1");
        step(0, '0, '0, '0, "R1");
        finish_run();
    end
endmodule